// File: doc/BRIEF.md
# Boost Phase Pulse Controller

This block produces the gate pulse train for a boost converter that charges a capacitive high-voltage load. Three comparator flags report the converter output against three rising levels: low, mid and target. A start request arms the controller. It then steps forward through three charging phases, and each phase has its own programmable pulse high time and low time. The first phase uses long, coarse pulses. The later phases use shorter, finer pulses so that the output overshoots less near the end. When the target flag is seen, pulsing stops and the converter stays idle until the next start.

The three high/low code pairs sit in a small table that is loaded over a bit-serial interface synchronous to the block clock. The pulse generator counts clock cycles. It reads a new code pair only at the start of a pulse period, so a phase change never cuts a pulse short. The comparator flags are asynchronous, so they pass through a two-flop synchronizer before the phase logic uses them.

Top module: `boost_phase_pulser`

## Requirements
- R1: While reset is held, and after it is released with no stimulus, `phaseState` reads 0 (idle) and `gateOut` is low. The table resets to the pairs (high, low) = (6,6) for set 0, (3,4) for set 1 and (1,2) for set 2.
- R2: A `startReq` sampled while `phaseState` is 0 (idle) or 4 (done) makes `phaseState` read 1 after that edge. A `startReq` sampled in phases 1 to 3 has no effect.
- R3: `phaseState` codes are 0 idle, 1/2/3 charging phases, 4 done. Phases only move forward: in phase 1 the target flag leads to 4, else the mid flag leads to 3, else the low flag leads to 2. In phase 2 the target flag leads to 4, else the mid flag leads to 3. In phase 3 the target flag leads to 4. A flag that drops never moves the phase back.
- R4: `cmpRaw` bit 0 is the low flag, bit 1 the mid flag and bit 2 the target flag. A flag value sampled at clock edge e changes `phaseState` after edge e+2.
- R5: A pulse is high for max(h,1)·HI_SCALE cycles and low for max(l,1)·LO_SCALE cycles, where h and l are the codes of the set in use. A code of 0 acts as 1. The defaults are HI_SCALE = 2 and LO_SCALE = 1.
- R6: Phase 1, 2 or 3 selects set 0, 1 or 2 respectively. The first pulse rises after the edge that follows the one where `phaseState` became 1.
- R7: A set change takes effect only when a full period (high then low) has ended. The period in progress finishes with the codes it started with.
- R8: Once `phaseState` leaves the charging phases, `gateOut` is low from the following edge onward. Done (4) holds until a start request or reset.
- R9: Each `serValid` cycle shifts `serBit` into a 12-bit frame, MSB first. Bits 11:10 give the set index, bits 9:5 the high code and bits 4:0 the low code. `serCommit` writes the frame into set 0, 1 or 2. Index 3 is discarded.
- R10: A `serCommit` sampled while `phaseState` is 1, 2 or 3 leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one cycle is the time unit |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Arms a charging run |
| cmpRaw | input | 3 | Asynchronous comparator flags {target, mid, low} |
| serValid | input | 1 | Shift enable for serial data |
| serBit | input | 1 | Serial data bit |
| serCommit | input | 1 | Writes the shifted frame into the table |
| gateOut | output | 1 | Switch gate pulse |
| phaseState | output | 3 | Current phase code |

## Verification
Each result has a fixed latency. Start shows in `phaseState` one edge later and the first gate rise follows one edge after that. A flag change reaches `phaseState` three edges after it is applied, and the gate falls one edge after that. Pulse edges fall exactly on the counted high and low lengths. The bench keeps an integer model that updates on each rising edge using the values sampled before that edge. It compares `gateOut` and `phaseState` against the model on every falling edge, so every latency above is checked to the exact cycle. The stimulus changes flags mid-period, drops a flag, skips phases, and writes the table while a run is active.

// File: rtl/bpp_pkg.sv
`timescale 1ns/1ps
package bpp_pkg;
  localparam int CODE_W   = 5;
  localparam int IDX_W    = 2;
  localparam int NUM_SETS = 3;
  localparam int FRAME_W  = IDX_W + 2 * CODE_W;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ONE   = 3'd1,
    PH_TWO   = 3'd2,
    PH_THREE = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

  typedef struct packed {
    logic             run;
    logic             launch;
    logic [IDX_W-1:0] setSel;
  } ctl_strobe_t;

  typedef struct packed {
    logic [CODE_W-1:0] hiCode;
    logic [CODE_W-1:0] loCode;
  } code_pair_t;

  function automatic code_pair_t resetPair(input int s);
    code_pair_t p;
    case (s)
      0:       begin p.hiCode = CODE_W'(6); p.loCode = CODE_W'(6); end
      1:       begin p.hiCode = CODE_W'(3); p.loCode = CODE_W'(4); end
      default: begin p.hiCode = CODE_W'(1); p.loCode = CODE_W'(2); end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/bpp_phase_ctrl.sv
`timescale 1ns/1ps
module bpp_phase_ctrl
  import bpp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic [2:0]  cmpRaw,
  output ctl_strobe_t ctl,
  output logic [2:0]  phaseState
);
  logic [2:0] syncPipe [SYNC_STAGES];
  logic [2:0] flags;
  phase_e     phase, nextPhase;
  logic       launchReg, launchNext;
  logic       isActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe[0] <= '0;
    else       syncPipe[0] <= cmpRaw;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncPipe[i] <= '0;
      else       syncPipe[i] <= syncPipe[i-1];
    end
  end

  assign flags = syncPipe[SYNC_STAGES-1];

  always_comb begin
    nextPhase  = phase;
    launchNext = 1'b0;
    case (phase)
      PH_IDLE, PH_DONE: if (startReq) begin
        nextPhase  = PH_ONE;
        launchNext = 1'b1;
      end
      PH_ONE: begin
        if (flags[2])      nextPhase = PH_DONE;
        else if (flags[1]) nextPhase = PH_THREE;
        else if (flags[0]) nextPhase = PH_TWO;
      end
      PH_TWO: begin
        if (flags[2])      nextPhase = PH_DONE;
        else if (flags[1]) nextPhase = PH_THREE;
      end
      PH_THREE: if (flags[2]) nextPhase = PH_DONE;
      default: nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      launchReg <= 1'b0;
    end else begin
      phase     <= nextPhase;
      launchReg <= launchNext;
    end
  end

  assign isActive   = (phase == PH_ONE) || (phase == PH_TWO) || (phase == PH_THREE);
  assign ctl.run    = isActive;
  assign ctl.launch = launchReg;
  assign ctl.setSel = isActive ? IDX_W'(phase - PH_ONE) : '0;
  assign phaseState = phase;

  // R3: phases never step backward while charging
  p_fwd_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    isActive |=> (phase >= $past(phase)));

  // R8: done holds without a start
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE && !startReq) |=> (phase == PH_DONE));

  // R2: an accepted start enters phase 1 with a launch strobe
  p_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_IDLE || phase == PH_DONE) && startReq) |=> (phase == PH_ONE && launchReg));
endmodule

// File: rtl/bpp_pulse_path.sv
`timescale 1ns/1ps
module bpp_pulse_path
  import bpp_pkg::*;
#(
  parameter int HI_SCALE = 2,
  parameter int LO_SCALE = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctl_strobe_t ctl,
  input  logic        serValid,
  input  logic        serBit,
  input  logic        serCommit,
  output logic        gateOut
);
  localparam int MAX_SCALE = (HI_SCALE > LO_SCALE) ? HI_SCALE : LO_SCALE;
  localparam int MAX_TICKS = ((1 << CODE_W) - 1) * MAX_SCALE;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [FRAME_W-1:0]  frame;
  logic [IDX_W-1:0]    frameIdx;
  code_pair_t          framePair;
  code_pair_t [NUM_SETS-1:0] setTable;
  logic [NUM_SETS-1:0] wrEn;
  logic                commitOk;

  logic [IDX_W-1:0]    selIdx;
  code_pair_t          selPair;
  logic [CNT_W-1:0]    selHi, selLo;
  logic [CNT_W-1:0]    cnt, curLo;
  logic                boundary;

  function automatic logic [CNT_W-1:0] ticksOf(input logic [CODE_W-1:0] code, input int scale);
    logic [CNT_W-1:0] base;
    base = (code == '0) ? CNT_W'(1) : CNT_W'(code);
    return CNT_W'(base * CNT_W'(scale));
  endfunction

  // serial loader
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         frame <= '0;
    else if (serValid) frame <= {frame[FRAME_W-2:0], serBit};
  end

  assign frameIdx         = frame[FRAME_W-1 -: IDX_W];
  assign framePair.hiCode = frame[2*CODE_W-1 -: CODE_W];
  assign framePair.loCode = frame[CODE_W-1:0];
  assign commitOk         = serCommit && !ctl.run;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_wr
    assign wrEn[s] = commitOk && (frameIdx == IDX_W'(s));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) setTable[s] <= resetPair(s);
    end else begin
      for (int s = 0; s < NUM_SETS; s++)
        if (wrEn[s]) setTable[s] <= framePair;
    end
  end

  // pulse generator
  assign selIdx   = (int'(ctl.setSel) < NUM_SETS) ? ctl.setSel : '0;
  assign selPair  = setTable[selIdx];
  assign selHi    = ticksOf(selPair.hiCode, HI_SCALE);
  assign selLo    = ticksOf(selPair.loCode, LO_SCALE);
  assign boundary = ctl.launch || (cnt == '0 && !gateOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateOut <= 1'b0;
      cnt     <= '0;
      curLo   <= CNT_W'(1);
    end else if (!ctl.run) begin
      gateOut <= 1'b0;
      cnt     <= '0;
    end else if (boundary) begin
      gateOut <= 1'b1;
      cnt     <= selHi - 1'b1;
      curLo   <= selLo;
    end else if (cnt != '0) begin
      cnt     <= cnt - 1'b1;
    end else begin
      gateOut <= 1'b0;
      cnt     <= curLo - 1'b1;
    end
  end

  // R8: no pulse once charging has stopped
  p_gate_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.run |=> !gateOut);

  // R5: counter stays inside the longest programmable time
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAX_TICKS - 1));

  // R10: table frozen while charging
  p_table_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |=> $stable(setTable));
endmodule

// File: rtl/boost_phase_pulser.sv
`timescale 1ns/1ps
module boost_phase_pulser
  import bpp_pkg::*;
#(
  parameter int HI_SCALE    = 2,
  parameter int LO_SCALE    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [2:0] cmpRaw,
  input  logic       serValid,
  input  logic       serBit,
  input  logic       serCommit,
  output logic       gateOut,
  output logic [2:0] phaseState
);
  ctl_strobe_t ctl;

  bpp_phase_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .cmpRaw     (cmpRaw),
    .ctl        (ctl),
    .phaseState (phaseState)
  );

  bpp_pulse_path #(.HI_SCALE(HI_SCALE), .LO_SCALE(LO_SCALE)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .serValid  (serValid),
    .serBit    (serBit),
    .serCommit (serCommit),
    .gateOut   (gateOut)
  );
endmodule

// File: tb/sim_boost_phase_pulser.sv
`timescale 1ns/1ps
module sim_boost_phase_pulser;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [2:0] cmpRaw = 3'b000;
  logic serValid = 1'b0, serBit = 1'b0, serCommit = 1'b0;
  logic gateOut;
  logic [2:0] phaseState;

  int total = 0, bad = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  boost_phase_pulser u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpRaw(cmpRaw),
    .serValid(serValid), .serBit(serBit), .serCommit(serCommit),
    .gateOut(gateOut), .phaseState(phaseState)
  );

  // behavioural reference model
  int mPh, mLaunch, mGate, mCnt, mCurLo, mShift, mS1, mS2;
  int mHi[3], mLo[3];

  function automatic int eff(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  task automatic modelReset();
    mPh = 0; mLaunch = 0; mGate = 0; mCnt = 0; mCurLo = 1;
    mShift = 0; mS1 = 0; mS2 = 0;
    mHi[0] = 6; mLo[0] = 6; mHi[1] = 3; mLo[1] = 4; mHi[2] = 1; mLo[2] = 2;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      int nPh, nLaunch, nGate, nCnt, nCurLo, idx;
      bit active;
      nPh = mPh; nLaunch = 0; nGate = mGate; nCnt = mCnt; nCurLo = mCurLo;
      active = (mPh >= 1 && mPh <= 3);
      if (!active) begin nGate = 0; nCnt = 0; end
      else if (mLaunch != 0 || (mCnt == 0 && mGate == 0)) begin
        nGate = 1; nCnt = eff(mHi[mPh-1]) * 2 - 1; nCurLo = eff(mLo[mPh-1]);
      end else if (mCnt != 0) nCnt = mCnt - 1;
      else begin nGate = 0; nCnt = mCurLo - 1; end
      if (serCommit && !active) begin
        idx = (mShift >> 10) & 3;
        if (idx < 3) begin mHi[idx] = (mShift >> 5) & 31; mLo[idx] = mShift & 31; end
      end
      if (serValid) mShift = ((mShift << 1) | int'(serBit)) & 12'hFFF;
      if ((mPh == 0 || mPh == 4) && startReq) begin nPh = 1; nLaunch = 1; end
      else if (active) begin
        if (mS2[2]) nPh = 4;
        else if (mS2[1] && mPh < 3) nPh = 3;
        else if (mS2[0] && mPh < 2) nPh = 2;
      end
      mS2 = mS1; mS1 = int'(cmpRaw);
      mPh = nPh; mLaunch = nLaunch; mGate = nGate; mCnt = nCnt; mCurLo = nCurLo;
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check(curReq, int'(gateOut), mGate, "gateOut");
      check(curReq, int'(phaseState), mPh, "phaseState");
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input int idx, input int hi, input int lo);
    logic [11:0] f;
    f = {2'(idx), 5'(hi), 5'(lo)};
    for (int b = 11; b >= 0; b--) begin
      @(negedge clk); serValid = 1'b1; serBit = f[b];
    end
    @(negedge clk); serValid = 1'b0; serCommit = 1'b1;
    @(negedge clk); serCommit = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    waitCyc(3);
    check("R1", int'(phaseState), 0, "phase in reset");
    check("R1", int'(gateOut), 0, "gate in reset");
    rstN = 1'b1;
    waitCyc(4);
    check("R1", int'(phaseState), 0, "phase after reset");

    // R9: load table; index 3 discarded; code 0 for R5
    curReq = "R9";
    sendFrame(0, 2, 3);
    sendFrame(1, 0, 0);
    sendFrame(2, 5, 1);
    sendFrame(3, 31, 31);

    // R6 / R5: start and run phase 1 pulses
    curReq = "R6";
    pulseStart();
    waitCyc(37);

    // R10: commit while active must not land
    curReq = "R10";
    sendFrame(0, 9, 9);

    // R2: start while active is ignored
    curReq = "R2";
    pulseStart();
    waitCyc(5);

    // R7 / R4: low flag mid-period, set change at boundary
    curReq = "R7";
    cmpRaw = 3'b001;
    waitCyc(31);

    // R3: drop flag, no regression; then mid flag
    curReq = "R3";
    cmpRaw = 3'b000;
    waitCyc(17);
    cmpRaw = 3'b011;
    curReq = "R5";
    waitCyc(29);

    // R8: target stops pulsing, done holds
    curReq = "R8";
    cmpRaw = 3'b111;
    waitCyc(20);
    cmpRaw = 3'b000;
    waitCyc(12);

    // R2: restart from done; R10 write absent from set 0
    curReq = "R2";
    pulseStart();
    waitCyc(23);

    // R3: skip straight to done from phase 1; R4 latency
    curReq = "R4";
    cmpRaw = 3'b111;
    waitCyc(15);

    // R9: write while idle/done lands, then rerun
    curReq = "R9";
    cmpRaw = 3'b000;
    sendFrame(0, 1, 1);
    pulseStart();
    waitCyc(20);
    curReq = "R3";
    cmpRaw = 3'b010;
    waitCyc(20);
    cmpRaw = 3'b100;
    waitCyc(10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule